// File: doc/BRIEF.md
# Display Fetch Sequencer with Refresh Interference

This block fetches display data for a small video controller from slow dynamic memory. A free-running 3-bit position counter divides time into 8-clock display cycles, each covering 16 pixels. Each cycle holds two bursts. A burst opens one memory row and strobes two columns: the first column returns a pixel byte and the second returns the attribute byte that belongs to it. When the cycle ends, the block presents both pixel/attribute pairs together at its outputs.

The block also reproduces the visible damage that CPU memory refresh causes. The CPU's refresh strobe drives the same row-strobe line that the video fetch uses. Two alignments of that strobe against the display cycle corrupt the fetch:

- If the refresh clock falls on position 2, the first burst opens the refresh row. That row comes from the CPU's R register, so the fetch returns "snow".
- If the refresh clock falls on position 4, the second burst never issues its column strobes. The first pair is shown a second time.

This corruption only happens when the I register points into slow memory. The mode input chooses how slow memory is decoded: off, the base map, or the banked map.

Top module: `vid_fetch_seq`

## Requirements
- R1: While reset is asserted, pix1, attr1, pix2 and attr2 read 0, and ras_n and cas_n read 1.
- R2: The first clock after reset is position 0, and the position advances by one every clock, modulo 8. Addresses are sampled at the end of position 1. ras_n is low in positions 2 to 5 and high in positions 6, 7, 0 and 1. The four output bytes change only at the end of position 5.
- R3: Position 2 presents row pix_addr[6:0] and column pix_addr[13:7] with cas_n low. Position 3 keeps the same row and presents column attr_addr[13:7]. Positions 4 and 5 do the same with pix_addr+1 and attr_addr+1. The bytes read in positions 2, 3, 4 and 5 become pix1, attr1, pix2 and attr2.
- R4: A clock in which mreq_n and rfsh_n are both low marks the next clock as the refresh clock. r_reg is sampled at the same edge.
- R5: If the refresh clock is position 2 and memory is slow, positions 2 and 3 present row r_reg[6:0]. Bit 7 of r_reg has no effect. pix1 and attr1 then come from that row.
- R6: If the refresh clock is position 4 and memory is slow, cas_n stays high in positions 4 and 5. pix2 and attr2 then equal pix1 and attr1.
- R7: A refresh clock at positions 0, 1, 3, 5, 6 or 7 leaves both bursts unchanged.
- R8: In base mode (slow_mode = 01), memory counts as slow only when i_reg[7:6] = 01. For example, i_reg = 0x80 causes no corruption.
- R9: In banked mode (slow_mode = 10 or 11), memory also counts as slow when i_reg[7:6] = 11 and bank_page is odd. An even bank_page, or base mode, makes that same I value harmless.
- R10: In mode 00, no alignment corrupts the fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_addr | input | 14 | Address of the first pixel byte of the cycle |
| attr_addr | input | 14 | Address of the first attribute byte of the cycle |
| mreq_n | input | 1 | CPU memory request, active low |
| rfsh_n | input | 1 | CPU refresh indicator, active low |
| r_reg | input | 8 | CPU refresh register value, already incremented |
| i_reg | input | 8 | CPU interrupt-vector register value |
| bank_page | input | 3 | Page mapped into the upper 16K window |
| slow_mode | input | 2 | 00 off, 01 base map, 1x banked map |
| dram_data | input | 8 | Read data from memory |
| dram_row | output | 7 | Row address |
| dram_col | output | 7 | Column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| pix1 | output | 8 | First pixel byte |
| attr1 | output | 8 | First attribute byte |
| pix2 | output | 8 | Second pixel byte |
| attr2 | output | 8 | Second attribute byte |

## Verification
The assertions check the following on every clock:
- the strobe envelope: column strobe only inside an open row, and no strobes in positions 6 to 1;
- the output bytes holding still outside position 5;
- a substituted row whenever a refresh hits position 2;
- a silent second burst whenever a refresh hits position 4.

Only the bench scenarios can show the rest, because that depends on the memory contents and the slow-memory decode:
- that the bytes really come from the expected addresses;
- that a repeated pair equals the first pair;
- that the six harmless alignments and the fast or disabled memory maps leave the data intact.

// File: rtl/vf_pkg.sv
package vf_pkg;
   localparam int PH_W = 3;
   typedef logic [PH_W-1:0] phase_t;

   localparam phase_t PH_ADDR_CAP = 3'd1;
   localparam phase_t PH_B1_PIX   = 3'd2;
   localparam phase_t PH_B1_ATT   = 3'd3;
   localparam phase_t PH_B2_PIX   = 3'd4;
   localparam phase_t PH_B2_ATT   = 3'd5;

   localparam logic [1:0] MODE_OFF  = 2'b00;
   localparam logic [1:0] MODE_BASE = 2'b01;
endpackage

// File: rtl/vf_phase_ctr.sv
module vf_phase_ctr
   import vf_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   output phase_t phase
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) phase <= '0;
      else        phase <= phase + 1'b1;
   end
endmodule

// File: rtl/vf_slow_dec.sv
module vf_slow_dec
   import vf_pkg::*;
#(
   parameter int REG_W     = 8,
   parameter int PAGE_W    = 3,
   parameter bit HAS_BANKS = 1'b1
) (
   input  logic [REG_W-1:0]  i_reg,
   input  logic [PAGE_W-1:0] bank_page,
   input  logic [1:0]        slow_mode,
   output logic              slow
);
   localparam int TOP_SHIFT = REG_W - 2;

   logic [1:0] win;
   logic       low_slow;
   logic       high_slow;

   assign win      = 2'(i_reg >> TOP_SHIFT);
   assign low_slow = (slow_mode != MODE_OFF) && (win == 2'b01);

   generate
      if (HAS_BANKS) begin : g_banked
         logic odd_page;
         assign odd_page  = (bank_page & PAGE_W'(1)) != '0;
         assign high_slow = slow_mode[1] && (win == 2'b11) && odd_page;
      end else begin : g_flat
         assign high_slow = (bank_page != bank_page) && slow_mode[1];
      end
   endgenerate

   assign slow = low_slow || high_slow;
endmodule

// File: rtl/vf_rfsh_tap.sv
module vf_rfsh_tap #(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mreq_n,
   input  logic             rfsh_n,
   input  logic             slow,
   input  logic [REG_W-1:0] r_reg,
   output logic             hit,
   output logic [REG_W-1:0] r_snap
);
   logic strobe;
   assign strobe = !mreq_n && !rfsh_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hit    <= 1'b0;
         r_snap <= '0;
      end else begin
         hit <= strobe && slow;
         if (strobe) r_snap <= r_reg;
      end
   end
endmodule

// File: rtl/vf_burst.sv
module vf_burst
   import vf_pkg::*;
#(
   parameter int ROW_W  = 7,
   parameter int COL_W  = 7,
   parameter int DATA_W = 8,
   parameter int REG_W  = 8,
   localparam int ADDR_W = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  phase_t            phase,
   input  logic [ADDR_W-1:0] pix_addr,
   input  logic [ADDR_W-1:0] attr_addr,
   input  logic              hit,
   input  logic [REG_W-1:0]  r_snap,
   input  logic [DATA_W-1:0] dram_data,
   output logic [ROW_W-1:0]  dram_row,
   output logic [COL_W-1:0]  dram_col,
   output logic              ras_n,
   output logic              cas_n,
   output logic [DATA_W-1:0] pix1,
   output logic [DATA_W-1:0] attr1,
   output logic [DATA_W-1:0] pix2,
   output logic [DATA_W-1:0] attr2
);
   logic [ADDR_W-1:0] pix_q, att_q, pix_n, att_n;
   logic [ROW_W-1:0]  row1_q;
   logic [DATA_W-1:0] pix1_s, att1_s, pix2_s;
   logic              dup_q;
   logic              snow_now, dup_now;

   assign pix_n    = pix_q + 1'b1;
   assign att_n    = att_q + 1'b1;
   assign snow_now = hit && (phase == PH_B1_PIX);
   assign dup_now  = hit && (phase == PH_B2_PIX);

   always_comb begin
      ras_n    = 1'b1;
      cas_n    = 1'b1;
      dram_row = pix_q[ROW_W-1:0];
      dram_col = '0;
      case (phase)
         PH_B1_PIX: begin
            ras_n    = 1'b0;
            cas_n    = 1'b0;
            dram_row = snow_now ? ROW_W'(r_snap) : pix_q[ROW_W-1:0];
            dram_col = pix_q[ADDR_W-1:ROW_W];
         end
         PH_B1_ATT: begin
            ras_n    = 1'b0;
            cas_n    = 1'b0;
            dram_row = row1_q;
            dram_col = att_q[ADDR_W-1:ROW_W];
         end
         PH_B2_PIX: begin
            ras_n = 1'b0;
            if (dup_now) begin
               dram_row = row1_q;
            end else begin
               cas_n    = 1'b0;
               dram_row = pix_n[ROW_W-1:0];
               dram_col = pix_n[ADDR_W-1:ROW_W];
            end
         end
         PH_B2_ATT: begin
            ras_n = 1'b0;
            if (dup_q) begin
               dram_row = row1_q;
            end else begin
               cas_n    = 1'b0;
               dram_row = pix_n[ROW_W-1:0];
               dram_col = att_n[ADDR_W-1:ROW_W];
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pix_q  <= '0;
         att_q  <= '0;
         row1_q <= '0;
         pix1_s <= '0;
         att1_s <= '0;
         pix2_s <= '0;
         dup_q  <= 1'b0;
         pix1   <= '0;
         attr1  <= '0;
         pix2   <= '0;
         attr2  <= '0;
      end else begin
         case (phase)
            PH_ADDR_CAP: begin
               pix_q <= pix_addr;
               att_q <= attr_addr;
            end
            PH_B1_PIX: begin
               pix1_s <= dram_data;
               row1_q <= dram_row;
            end
            PH_B1_ATT: att1_s <= dram_data;
            PH_B2_PIX: begin
               dup_q  <= dup_now;
               pix2_s <= dup_now ? pix1_s : dram_data;
            end
            PH_B2_ATT: begin
               pix1  <= pix1_s;
               attr1 <= att1_s;
               pix2  <= pix2_s;
               attr2 <= dup_q ? att1_s : dram_data;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/vid_fetch_seq.sv
module vid_fetch_seq
   import vf_pkg::*;
#(
   parameter int ROW_W     = 7,
   parameter int COL_W     = 7,
   parameter int DATA_W    = 8,
   parameter int REG_W     = 8,
   parameter int PAGE_W    = 3,
   parameter bit HAS_BANKS = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [ROW_W+COL_W-1:0] pix_addr,
   input  logic [ROW_W+COL_W-1:0] attr_addr,
   input  logic                   mreq_n,
   input  logic                   rfsh_n,
   input  logic [REG_W-1:0]       r_reg,
   input  logic [REG_W-1:0]       i_reg,
   input  logic [PAGE_W-1:0]      bank_page,
   input  logic [1:0]             slow_mode,
   input  logic [DATA_W-1:0]      dram_data,
   output logic [ROW_W-1:0]       dram_row,
   output logic [COL_W-1:0]       dram_col,
   output logic                   ras_n,
   output logic                   cas_n,
   output logic [DATA_W-1:0]      pix1,
   output logic [DATA_W-1:0]      attr1,
   output logic [DATA_W-1:0]      pix2,
   output logic [DATA_W-1:0]      attr2
);
   initial begin
      assert (REG_W > ROW_W) else $error("refresh register narrower than row");
      assert (REG_W >= 2)    else $error("I register needs two top bits");
      assert (PAGE_W >= 1)   else $error("page width must be positive");
      assert (DATA_W >= 1)   else $error("data width must be positive");
   end

   phase_t             phase;
   logic               slow;
   logic               hit;
   logic [REG_W-1:0]   r_snap;

   vf_phase_ctr i_phase (
      .clk   (clk),
      .rst_n (rst_n),
      .phase (phase)
   );

   vf_slow_dec #(.REG_W(REG_W), .PAGE_W(PAGE_W), .HAS_BANKS(HAS_BANKS)) i_slow (
      .i_reg     (i_reg),
      .bank_page (bank_page),
      .slow_mode (slow_mode),
      .slow      (slow)
   );

   vf_rfsh_tap #(.REG_W(REG_W)) i_tap (
      .clk    (clk),
      .rst_n  (rst_n),
      .mreq_n (mreq_n),
      .rfsh_n (rfsh_n),
      .slow   (slow),
      .r_reg  (r_reg),
      .hit    (hit),
      .r_snap (r_snap)
   );

   vf_burst #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .REG_W(REG_W)) i_burst (
      .clk       (clk),
      .rst_n     (rst_n),
      .phase     (phase),
      .pix_addr  (pix_addr),
      .attr_addr (attr_addr),
      .hit       (hit),
      .r_snap    (r_snap),
      .dram_data (dram_data),
      .dram_row  (dram_row),
      .dram_col  (dram_col),
      .ras_n     (ras_n),
      .cas_n     (cas_n),
      .pix1      (pix1),
      .attr1     (attr1),
      .pix2      (pix2),
      .attr2     (attr2)
   );
endmodule

// File: rtl/vf_fetch_chk.sv
module vf_fetch_chk
   import vf_pkg::*;
#(
   parameter int ROW_W  = 7,
   parameter int DATA_W = 8,
   parameter int REG_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input phase_t            phase,
   input logic              hit,
   input logic [REG_W-1:0]  r_snap,
   input logic [ROW_W-1:0]  dram_row,
   input logic              ras_n,
   input logic              cas_n,
   input logic [DATA_W-1:0] pix1,
   input logic [DATA_W-1:0] attr1,
   input logic [DATA_W-1:0] pix2,
   input logic [DATA_W-1:0] attr2
);
   assert_cas_in_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n);

   assert_idle_strobes_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase inside {3'd0, 3'd1, 3'd6, 3'd7}) |-> (ras_n && cas_n));

   assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (phase != PH_B2_ATT) |=> $stable({pix1, attr1, pix2, attr2}));

   assert_snow_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && phase == PH_B1_PIX) |-> (dram_row == ROW_W'(r_snap)));

   assert_dup_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && phase == PH_B2_PIX) |-> (cas_n && !ras_n));

   assert_dup_quiet_next_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && phase == PH_B2_PIX) |=> (cas_n && !ras_n));
endmodule

bind vid_fetch_seq vf_fetch_chk #(.ROW_W(ROW_W), .DATA_W(DATA_W), .REG_W(REG_W)) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .phase    (phase),
   .hit      (hit),
   .r_snap   (r_snap),
   .dram_row (dram_row),
   .ras_n    (ras_n),
   .cas_n    (cas_n),
   .pix1     (pix1),
   .attr1    (attr1),
   .pix2     (pix2),
   .attr2    (attr2)
);

// File: tb/test_vid_fetch_seq.sv
module test_vid_fetch_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [13:0] pix_addr = '0, attr_addr = '0;
   logic        mreq_n = 1'b1, rfsh_n = 1'b1;
   logic [7:0]  r_reg = '0, i_reg = '0;
   logic [2:0]  bank_page = '0;
   logic [1:0]  slow_mode = '0;
   logic [7:0]  dram_data;
   logic [6:0]  dram_row, dram_col;
   logic        ras_n, cas_n;
   logic [7:0]  pix1, attr1, pix2, attr2;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done  = 1'b0;
   logic [2:0] tb_pos;

   always #4 clk = ~clk;

   vid_fetch_seq i_vid_fetch_seq (
      .clk(clk), .rst_n(rst_n), .pix_addr(pix_addr), .attr_addr(attr_addr),
      .mreq_n(mreq_n), .rfsh_n(rfsh_n), .r_reg(r_reg), .i_reg(i_reg),
      .bank_page(bank_page), .slow_mode(slow_mode), .dram_data(dram_data),
      .dram_row(dram_row), .dram_col(dram_col), .ras_n(ras_n), .cas_n(cas_n),
      .pix1(pix1), .attr1(attr1), .pix2(pix2), .attr2(attr2)
   );

   function automatic logic [7:0] pat(input logic [13:0] a);
      return (a[7:0] ^ {1'b0, a[13:7]}) + 8'h35;
   endfunction

   assign dram_data = (!ras_n && !cas_n) ? pat({dram_col, dram_row}) : 8'h00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tb_pos <= '0;
      else        tb_pos <= tb_pos + 1'b1;
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // align: clock of the cycle the refresh lands on, -1 for no refresh
   task automatic run_group(input string req, input logic [13:0] pa, input logic [13:0] aa,
                            input logic [7:0] rv, input logic [7:0] iv, input logic [2:0] pg,
                            input logic [1:0] md, input int align);
      logic slow_e, snow_e, dup_e;
      logic [6:0]  row1;
      logic [13:0] pa2, aa2;
      logic [7:0]  ep1, ea1, ep2, ea2;
      slow_e = (md != 2'b00) && ((iv[7:6] == 2'b01) || (md[1] && iv[7:6] == 2'b11 && pg[0]));
      snow_e = slow_e && (align == 2);
      dup_e  = slow_e && (align == 4);
      row1   = snow_e ? rv[6:0] : pa[6:0];
      pa2 = pa + 14'd1;
      aa2 = aa + 14'd1;
      ep1 = pat({pa[13:7], row1});
      ea1 = pat({aa[13:7], row1});
      ep2 = dup_e ? ep1 : pat(pa2);
      ea2 = dup_e ? ea1 : pat({aa2[13:7], pa2[6:0]});
      while (tb_pos != 3'd7) @(negedge clk);
      pix_addr = pa; attr_addr = aa; i_reg = iv; bank_page = pg; slow_mode = md; r_reg = rv;
      for (int k = 0; k < 8; k++) begin
         if (align >= 0 && int'(tb_pos) == ((align + 7) % 8)) begin
            mreq_n = 1'b0; rfsh_n = 1'b0;
         end else begin
            mreq_n = 1'b1; rfsh_n = 1'b1;
         end
         if (tb_pos == 3'd2)
            check({req, " burst1 R3/R5"}, {48'd0, ras_n, cas_n, dram_col, dram_row},
                  {48'd0, 1'b0, 1'b0, pa[13:7], row1});
         if (tb_pos == 3'd4)
            check({req, " burst2 strobe R6/R2"}, {62'd0, ras_n, cas_n}, {62'd0, 1'b0, dup_e});
         if (tb_pos == 3'd6)
            check({req, " pairs R3/R6/R7"}, {32'd0, pix1, attr1, pix2, attr2},
                  {32'd0, ep1, ea1, ep2, ea2});
         @(negedge clk);
      end
      mreq_n = 1'b1; rfsh_n = 1'b1;
   endtask

   task automatic test_reset();
      repeat (3) @(negedge clk);
      check("reset R1", {30'd0, pix1, attr1, pix2, attr2, ras_n, cas_n}, {30'd0, 32'd0, 2'b11});
      rst_n = 1'b1;
      @(negedge clk);
      check("pos0 idle R2", {62'd0, ras_n, cas_n}, {62'd0, 2'b11});
   endtask

   task automatic test_align_sweep();
      for (int a = 0; a < 8; a++)
         run_group($sformatf("base align%0d R5/R6/R7/R4", a), 14'h1234, 14'h2A34, 8'hC9, 8'h5A, 3'd0, 2'b01, a);
   endtask

   task automatic test_r_bit7();
      run_group("r bit7 ignored R5", 14'h0A11, 14'h3311, 8'hFF, 8'h41, 3'd0, 2'b01, 2);
   endtask

   task automatic test_fast_i();
      run_group("fast I align2 R8", 14'h1234, 14'h2A34, 8'h66, 8'h80, 3'd1, 2'b01, 2);
      run_group("fast I align4 R8", 14'h1234, 14'h2A34, 8'h66, 8'hBF, 3'd1, 2'b10, 4);
   endtask

   task automatic test_banked();
      run_group("banked odd snow R9", 14'h0555, 14'h1955, 8'h13, 8'hC5, 3'd3, 2'b10, 2);
      run_group("banked odd dup R9", 14'h0555, 14'h1955, 8'h13, 8'hFF, 3'd7, 2'b11, 4);
      run_group("banked even R9", 14'h0555, 14'h1955, 8'h13, 8'hC5, 3'd2, 2'b10, 2);
      run_group("base upper R9", 14'h0555, 14'h1955, 8'h13, 8'hC5, 3'd3, 2'b01, 2);
   endtask

   task automatic test_off();
      run_group("mode off align2 R10", 14'h2222, 14'h3B22, 8'h7E, 8'h60, 3'd1, 2'b00, 2);
      run_group("mode off align4 R10", 14'h2222, 14'h3B22, 8'h7E, 8'h60, 3'd1, 2'b00, 4);
   endtask

   task automatic test_quiet_and_carry();
      run_group("no refresh R3", 14'h0F00, 14'h2D00, 8'h01, 8'h70, 3'd0, 2'b01, -1);
      run_group("row carry R3", 14'h107F, 14'h2E7F, 8'h01, 8'h70, 3'd0, 2'b01, -1);
   endtask

   initial begin
      test_reset();
      test_align_sweep();
      test_r_bit7();
      test_fast_i();
      test_banked();
      test_off();
      test_quiet_and_carry();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_err++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule